// File: doc/BRIEF.md
# Serial Flash Block-Protection Guard

This block sits beside the command decoder of a small serial NOR flash whose 512 KB array is split into eight 64 KB blocks. It keeps the write-protection state: a three-bit protection level and a lock bit. It accepts status-register write requests, and it judges every program, sector-erase and chip-erase request against that state.

The protection level selects a protected region that starts at the top of the array and grows downward. Each step doubles its size, up to the whole array. The lock bit works together with a sampled hardware write-protect pin. With the pin low and the lock set, the protection state is frozen. With the pin high, the lock has no effect on write permission, but its stored value is kept.

Every request receives exactly one verdict, one cycle later. The verdict is a one-cycle grant pulse or a one-cycle reject pulse. The decoder uses this verdict to start or abandon the array operation. The current protection state can always be read on an eight-bit status bus.

Top module: `flash_wp_guard`

## Requirements
- R1: After reset the lock bit is 0 and the level is 111, so `status_o` reads 0x1C and every program or erase is rejected.
- R2: The level maps to a protected block range as follows:
  - 000: no blocks.
  - 001: block 7 only.
  - 010: blocks 6..7.
  - 011: blocks 4..7.
  - 100 to 111: blocks 0..7.
- R3: The block number of a request is taken from `addr_i[18:16]`. A program or sector erase whose block is protected is rejected. Otherwise it is granted, provided `wel_i` is 1.
- R4: A chip erase is granted only when `wel_i` is 1 and the level is 000.
- R5: When `wel_i` is 0, every request is rejected and the status bits do not change.
- R6: A status write with `wel_i` = 1 is granted when `wp_n_i` is 1 or the lock bit is 0. A granted write loads the level from `sr_wdata_i[4:2]` and the lock bit from `sr_wdata_i[7]`. These new values apply from the next cycle.
- R7: When `wp_n_i` is 0 and the lock bit is 1, a status write is rejected and leaves both the lock bit and the level entirely unchanged.
- R8: When `wp_n_i` is 1, a stored lock bit of 1 does not block status writes. A lock bit of 1 is still kept and read back until it is overwritten.
- R9: The verdict for a request is a grant or a reject pulse that lasts exactly one cycle, in the cycle after the request. Grant and reject are never high together.
- R10: When requests arrive together, only one is judged. The order of priority is: status write, then chip erase, then sector erase, then program. The requests that lose produce no pulse.
- R11: `status_o` carries the lock bit in bit 7 and the level in bits 4..2. All other bits read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wel_i | input | 1 | Write-enable latch state; 1 allows modification requests |
| wp_n_i | input | 1 | Sampled write-protect pin, active low |
| sr_wr_i | input | 1 | Status-register write request |
| sr_wdata_i | input | 8 | Status-register write data |
| prog_req_i | input | 1 | Program request |
| serase_req_i | input | 1 | Sector-erase request |
| cerase_req_i | input | 1 | Chip-erase request |
| addr_i | input | 19 | Target byte address of a program or sector erase |
| grant_o | output | 1 | One-cycle pulse: request accepted |
| reject_o | output | 1 | One-cycle pulse: request denied |
| status_o | output | 8 | Lock bit and protection level |

## Verification
All eight levels are set in turn. At each level, program and sector erase are driven at the first and last byte of every block, with the write-enable latch both set and clear. This separates the boundary of each region, the off-by-one cases at block edges, and the write-enable gating. Chip erase is tried at every level, to tell level zero apart from all the others. Status writes are tried under all four combinations of pin and lock bit. These show that a frozen state is wholly preserved, that a high pin overrides the lock, and that the bits that are not used read as zero. A case with simultaneous requests shows the priority order, and shows that the requests which lose get no second pulse.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int LEVEL_W = 3;
    localparam int SR_W    = 8;
    localparam int LOCK_POS = 7;
    localparam int LVL_LSB  = 2;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WRSR  = 3'd1,
        OP_CHIP  = 3'd2,
        OP_SECT  = 3'd3,
        OP_PROG  = 3'd4
    } op_e;

    typedef struct packed {
        logic               lock;
        logic [LEVEL_W-1:0] level;
    } prot_t;

    typedef struct packed {
        logic grant;
        logic reject;
    } verdict_t;
endpackage

// File: rtl/wp_region_decode.sv
module wp_region_decode #(
    parameter int NUM_BLOCKS = 8,
    parameter int LEVEL_W    = 3
) (
    input  logic [LEVEL_W-1:0]    level_i,
    output logic [NUM_BLOCKS-1:0] prot_mask_o
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);
    localparam int CNT_W = BLK_W + 1;

    logic [CNT_W-1:0] prot_cnt;

    // Number of protected blocks counted down from the top block.
    always_comb begin
        if (level_i == '0) begin
            prot_cnt = '0;
        end else if (int'(level_i) - 1 >= BLK_W) begin
            prot_cnt = CNT_W'(NUM_BLOCKS);
        end else begin
            prot_cnt = CNT_W'(1) << (level_i - LEVEL_W'(1));
        end
    end

    generate
        for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
            assign prot_mask_o[g] = (CNT_W'(g) + prot_cnt) >= CNT_W'(NUM_BLOCKS);
        end
    endgenerate

    // R2: level zero leaves every block open; the top block is protected at any other level.
    always_comb begin
        assert_level_zero_open_R2: assert (level_i != '0 || prot_mask_o == '0);
        assert_top_block_R2: assert (level_i == '0 || prot_mask_o[NUM_BLOCKS-1]);
    end
endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg
    import wp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_sel_i,
    input  logic            wel_i,
    input  logic            wp_n_i,
    input  logic [SR_W-1:0] wdata_i,
    output logic            wr_ok_o,
    output prot_t           prot_o,
    output logic [SR_W-1:0] status_o
);
    prot_t prot_d, prot_q;
    logic  frozen;

    always_comb begin
        frozen  = !wp_n_i && prot_q.lock;
        wr_ok_o = wr_sel_i && wel_i && !frozen;
        prot_d  = prot_q;
        if (wr_ok_o) begin
            prot_d.lock  = wdata_i[LOCK_POS];
            prot_d.level = wdata_i[LVL_LSB +: LEVEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= '{lock: 1'b0, level: '1};
        end else begin
            prot_q <= prot_d;
        end
    end

    always_comb begin
        status_o                     = '0;
        status_o[LOCK_POS]           = prot_q.lock;
        status_o[LVL_LSB +: LEVEL_W] = prot_q.level;
    end

    assign prot_o = prot_q;

    logic unused_wdata;
    assign unused_wdata = ^{wdata_i[SR_W-1:LOCK_POS+1], wdata_i[LOCK_POS-1:LVL_LSB+LEVEL_W],
                            wdata_i[LVL_LSB-1:0]};

    // R7: a write under pin-low with lock set leaves the state untouched.
    assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel_i && !wp_n_i && prot_q.lock) |=> $stable(prot_q));

    // R5: without the write-enable latch the state does not move.
    assert_no_wel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wel_i) |=> $stable(prot_q));
endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int NUM_BLOCKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel_i,
    input  logic              wp_n_i,
    input  logic              sr_wr_i,
    input  logic [SR_W-1:0]   sr_wdata_i,
    input  logic              prog_req_i,
    input  logic              serase_req_i,
    input  logic              cerase_req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              grant_o,
    output logic              reject_o,
    output logic [SR_W-1:0]   status_o
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);

    op_e                  op;
    logic                 wr_ok;
    prot_t                prot;
    logic [NUM_BLOCKS-1:0] prot_mask;
    logic [BLK_W-1:0]     blk;
    logic                 blk_locked;
    verdict_t             verdict_d, verdict_q;

    // R10: one request per cycle, fixed priority.
    always_comb begin
        if (sr_wr_i)           op = OP_WRSR;
        else if (cerase_req_i) op = OP_CHIP;
        else if (serase_req_i) op = OP_SECT;
        else if (prog_req_i)   op = OP_PROG;
        else                   op = OP_NONE;
    end

    wp_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel_i (op == OP_WRSR),
        .wel_i    (wel_i),
        .wp_n_i   (wp_n_i),
        .wdata_i  (sr_wdata_i),
        .wr_ok_o  (wr_ok),
        .prot_o   (prot),
        .status_o (status_o)
    );

    wp_region_decode #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .LEVEL_W    (LEVEL_W)
    ) u_decode (
        .level_i     (prot.level),
        .prot_mask_o (prot_mask)
    );

    assign blk        = addr_i[ADDR_W-1 -: BLK_W];
    assign blk_locked = prot_mask[blk];

    always_comb begin
        verdict_d = '0;
        unique case (op)
            OP_WRSR: begin
                verdict_d.grant  = wr_ok;
                verdict_d.reject = !wr_ok;
            end
            OP_CHIP: begin
                verdict_d.grant  = wel_i && (prot.level == '0);
                verdict_d.reject = !verdict_d.grant;
            end
            OP_SECT, OP_PROG: begin
                verdict_d.grant  = wel_i && !blk_locked;
                verdict_d.reject = !verdict_d.grant;
            end
            default: verdict_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_q <= '0;
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign grant_o  = verdict_q.grant;
    assign reject_o = verdict_q.reject;

    logic unused_addr;
    assign unused_addr = ^addr_i[ADDR_W-BLK_W-1:0];

    // R9: grant and reject are exclusive.
    assert_one_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && reject_o));

    // R9: any request gets a verdict in the next cycle.
    assert_verdict_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_i || prog_req_i || serase_req_i || cerase_req_i) |=> (grant_o || reject_o));

    // R5: no write-enable latch, no grant.
    assert_wel_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((sr_wr_i || prog_req_i || serase_req_i || cerase_req_i) && !wel_i) |=> reject_o);

    // R4: chip erase with a nonzero level is refused.
    assert_chip_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CHIP && status_o[LVL_LSB +: LEVEL_W] != '0) |=> reject_o);

    // R3: a request into a protected block is refused.
    assert_block_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_SECT || op == OP_PROG) && prot_mask[blk]) |=> reject_o);
endmodule

// File: tb/flash_wp_guard_test.sv
module flash_wp_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wel_i = 1'b0, wp_n_i = 1'b1, sr_wr_i = 1'b0;
    logic [7:0]  sr_wdata_i = '0;
    logic        prog_req_i = 1'b0, serase_req_i = 1'b0, cerase_req_i = 1'b0;
    logic [18:0] addr_i = '0;
    logic        grant_o, reject_o;
    logic [7:0]  status_o;

    int total = 0;
    int bad = 0;

    flash_wp_guard uut (
        .clk(clk), .rst_n(rst_n), .wel_i(wel_i), .wp_n_i(wp_n_i),
        .sr_wr_i(sr_wr_i), .sr_wdata_i(sr_wdata_i), .prog_req_i(prog_req_i),
        .serase_req_i(serase_req_i), .cerase_req_i(cerase_req_i), .addr_i(addr_i),
        .grant_o(grant_o), .reject_o(reject_o), .status_o(status_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // kind: 0 status write, 1 chip erase, 2 sector erase, 3 program
    task automatic req(input int kind, input logic wl, input logic wp, input logic [7:0] d,
                       input logic [18:0] a, output logic g, output logic r);
        @(negedge clk);
        wel_i = wl; wp_n_i = wp; sr_wdata_i = d; addr_i = a;
        sr_wr_i = (kind == 0); cerase_req_i = (kind == 1);
        serase_req_i = (kind == 2); prog_req_i = (kind == 3);
        @(negedge clk);
        g = grant_o; r = reject_o;
        sr_wr_i = 0; cerase_req_i = 0; serase_req_i = 0; prog_req_i = 0;
    endtask

    function automatic logic blk_prot(input int lvl, input int b);
        int cnt;
        cnt = (lvl == 0) ? 0 : (lvl >= 4) ? 8 : (1 << (lvl - 1));
        return b >= 8 - cnt;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic g, r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", status_o, 8'h1C);
        chk("R1 reset no pulse", {grant_o, reject_o}, 0);
        req(3, 1, 1, 0, 19'h00000, g, r);
        chk("R1 reset program block0 rejected", {g, r}, 2'b01);

        // Level sweep.
        for (int lvl = 0; lvl < 8; lvl++) begin
            req(0, 1, 1, 8'(lvl << 2), 0, g, r);
            chk("R6 status write grant", {g, r}, 2'b10);
            chk("R6 status after write", status_o, lvl << 2);
            for (int b = 0; b < 8; b++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int k = 2; k < 4; k++) begin
                        logic [18:0] a;
                        logic exp_g;
                        a = 19'((b << 16) | (e ? 16'hFFFF : 16'h0000));
                        exp_g = !blk_prot(lvl, b);
                        req(k, 1, 1, 0, a, g, r);
                        chk($sformatf("R2 R3 lvl%0d blk%0d edge%0d kind%0d", lvl, b, e, k),
                            {g, r}, {exp_g, !exp_g});
                        req(k, 0, 1, 0, a, g, r);
                        chk("R5 program/erase without wel", {g, r}, 2'b01);
                    end
                end
            end
            req(1, 1, 1, 0, 0, g, r);
            chk($sformatf("R4 chip erase lvl%0d", lvl), {g, r}, (lvl == 0) ? 2'b10 : 2'b01);
            req(1, 0, 1, 0, 0, g, r);
            chk("R5 chip erase without wel", {g, r}, 2'b01);
        end

        // wel low status write ignored.
        req(0, 0, 1, 8'h00, 0, g, r);
        chk("R5 status write without wel rejected", {g, r}, 2'b01);
        chk("R5 status unchanged", status_o, 8'h1C);

        // Unused bits read zero.
        req(0, 1, 1, 8'hFF, 0, g, r);
        chk("R11 unused bits zero", status_o, 8'h9C);

        // Lock and level 2.
        req(0, 1, 1, 8'h88, 0, g, r);
        chk("R6 set lock", status_o, 8'h88);
        req(0, 1, 0, 8'h00, 0, g, r);
        chk("R7 frozen write rejected", {g, r}, 2'b01);
        chk("R7 frozen state kept", status_o, 8'h88);
        req(0, 1, 0, 8'h0C, 0, g, r);
        chk("R7 frozen level-only write kept", status_o, 8'h88);
        req(2, 1, 0, 0, 19'h60000, g, r);
        chk("R7 level still active block6", {g, r}, 2'b01);
        req(0, 1, 1, 8'h84, 0, g, r);
        chk("R8 pin high overrides lock", {g, r}, 2'b10);
        chk("R8 lock kept with new level", status_o, 8'h84);
        req(0, 1, 1, 8'h00, 0, g, r);
        chk("R8 clear under pin high", status_o, 8'h00);
        req(0, 1, 0, 8'h10, 0, g, r);
        chk("R6 pin low lock clear writes", {g, r}, 2'b10);
        chk("R6 pin low lock clear status", status_o, 8'h10);

        // Priority: status write beats program into protected block.
        @(negedge clk);
        wel_i = 1; wp_n_i = 1; sr_wdata_i = 8'h00; addr_i = 0;
        sr_wr_i = 1; prog_req_i = 1;
        @(negedge clk);
        chk("R10 status write wins", {grant_o, reject_o}, 2'b10);
        chk("R10 status applied", status_o, 8'h00);
        sr_wr_i = 0; prog_req_i = 0;
        @(negedge clk);
        chk("R9 pulse lasts one cycle", {grant_o, reject_o}, 0);
        // Chip erase beats sector erase.
        req(0, 1, 1, 8'h04, 0, g, r);
        @(negedge clk);
        cerase_req_i = 1; serase_req_i = 1; addr_i = 19'h00000;
        @(negedge clk);
        chk("R10 chip erase wins over sector erase", {grant_o, reject_o}, 2'b01);
        cerase_req_i = 0; serase_req_i = 0;
        @(negedge clk);
        chk("R9 no second pulse", {grant_o, reject_o}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule